// File: doc/BRIEF.md
# Encoder-Compensated Scan Mirror Coordinate Unit

This block turns virtual marking coordinates into physical scan-mirror coordinates for a workpiece that rotates under the marking head. A rotary encoder with quadrature outputs feeds a signed position accumulator. Each decoded encoder step moves the accumulator by a programmable step size, up or down depending on the direction of rotation. Two origin offsets, one per axis, are held in configuration registers.

A virtual X/Y pair arrives as one command. The command is accepted in a single cycle whenever the output slot is free. The unit then presents the physical pair on a valid/ready output towards the mirror serializer. The X result subtracts the live encoder advance, so it keeps following the rotation for as long as the output is held, with no new command needed. The Y result takes no encoder term.

Configuration register map (`cfgAddr`): 0 = encoder step magnitude (unsigned), 1 = X origin offset, 2 = Y origin offset, 3 = unused (ignored). All offsets and coordinates are 16-bit two's complement.

Top module: `galvo_coord_unit`

## Requirements
- R1: While `outValid` is high, `physX` equals offX + cmdX − acc, saturated to the signed 16-bit range. offX is the X offset in force when the command was accepted, and acc is the current accumulator value.
- R2: `physY` equals offY + cmdY, saturated to the signed 16-bit range, with no encoder term.
- R3: A forward quadrature step adds the step magnitude to the accumulator. Forward is the sequence {quadA,quadB} = 00→10→11→01→00, and the inputs pass through a two-flop synchronizer.
- R4: A reverse step (the opposite sequence) subtracts the step magnitude from the accumulator.
- R5: The physical results and the accumulator saturate at −32768 and 32767 and never wrap.
- R6: A write to register 0 loads the step magnitude and zeroes the accumulator.
- R7: Writes to the offset registers change no output that is already presented. They take effect on the next accepted command.
- R8: `cmdReady` = !outValid || outReady. A command is accepted only when `cmdValid` and `cmdReady` are both high, so a command offered while the output is held without ready is ignored. `outValid` drops after a cycle with `outReady` high and no new command.
- R9: While an output is held, each encoder step changes `physX` without any new command.
- R10: A transition in which both quadrature bits change at once produces no step.
- R11: After reset, `outValid` is low, `cmdReady` is high, and the accumulator and both offsets are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| quadA | input | 1 | Encoder channel A, asynchronous |
| quadB | input | 1 | Encoder channel B, asynchronous |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgWrData | input | 16 | Configuration write data |
| cmdValid | input | 1 | Virtual coordinate command present |
| cmdReady | output | 1 | Command would be accepted this cycle |
| cmdX | input | 16 | Virtual X, signed |
| cmdY | input | 16 | Virtual Y, signed |
| outValid | output | 1 | Physical coordinate pair valid |
| outReady | input | 1 | Serializer takes the pair |
| physX | output | 16 | Physical X, signed, encoder-corrected |
| physY | output | 16 | Physical Y, signed |

## Verification
The assertions take for granted that the encoder inputs change no faster than one transition per three clocks. Otherwise a step could slip past the synchronizer unseen. They also assume that `cmdValid` and the configuration strobe are driven to known values from reset onward. The stimulus holds each quadrature level for five cycles. It makes illegal two-bit jumps only on purpose, to exercise R10. It drives every handshake and configuration input on the falling edge, so each one is stable across the rising edge that samples it.

// File: rtl/gcu_pkg.sv
package gcu_pkg;
  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic loadCmd;   // latch a new command into the output slot
    logic clearAcc;  // zero the encoder accumulator
    logic stepUp;    // forward encoder step
    logic stepDown;  // reverse encoder step
    logic wrStep;    // load step magnitude
    logic wrOffX;    // load X origin offset
    logic wrOffY;    // load Y origin offset
  } gcuStrobes_t;
endpackage

// File: rtl/gcu_ctrl.sv
module gcu_ctrl
  import gcu_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              quadA,
  input  logic              quadB,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cmdValid,
  input  logic              outReady,
  output logic              cmdReady,
  output logic              outValid,
  output gcuStrobes_t       strobes
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_OFFX = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_OFFY = ADDR_W'(2);

  logic [SYNC_STAGES-1:0] syncA, syncB;
  logic [1:0] qNow, qPrev, qDelta;
  logic legalMove, fwdMove;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      qPrev <= '0;
    end else begin
      syncA <= {syncA[SYNC_STAGES-2:0], quadA};
      syncB <= {syncB[SYNC_STAGES-2:0], quadB};
      qPrev <= qNow;
    end
  end

  assign qNow      = {syncA[SYNC_STAGES-1], syncB[SYNC_STAGES-1]};
  assign qDelta    = qNow ^ qPrev;
  assign legalMove = ^qDelta;               // exactly one channel moved
  assign fwdMove   = qNow[1] ^ qPrev[0];    // A leads B when set

  assign cmdReady = !outValid || outReady;

  always_comb begin
    strobes          = '0;
    strobes.loadCmd  = cmdValid && cmdReady;
    strobes.stepUp   = legalMove && fwdMove;
    strobes.stepDown = legalMove && !fwdMove;
    strobes.wrStep   = cfgWrEn && (cfgAddr == ADDR_STEP);
    strobes.wrOffX   = cfgWrEn && (cfgAddr == ADDR_OFFX);
    strobes.wrOffY   = cfgWrEn && (cfgAddr == ADDR_OFFY);
    strobes.clearAcc = strobes.wrStep;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 outValid <= 1'b0;
    else if (strobes.loadCmd)  outValid <= 1'b1;
    else if (outReady)         outValid <= 1'b0;
  end

  // R8: a held output without ready stays valid
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R8: the output only becomes valid through an offered command
  p_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(cmdValid));

  // R10: a two-bit jump of the synchronized inputs never counts
  p_no_double_r10: assert property (@(posedge clk) disable iff (!rstN)
    (syncA[SYNC_STAGES-1] != qPrev[1] && syncB[SYNC_STAGES-1] != qPrev[0])
      |-> !(strobes.stepUp || strobes.stepDown));
endmodule

// File: rtl/gcu_datapath.sv
module gcu_datapath
  import gcu_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  gcuStrobes_t               strobes,
  input  logic        [COORD_W-1:0] cfgWrData,
  input  logic signed [COORD_W-1:0] cmdX,
  input  logic signed [COORD_W-1:0] cmdY,
  output logic signed [COORD_W-1:0] physX,
  output logic signed [COORD_W-1:0] physY
);
  localparam int WIDE = COORD_W + 2;
  localparam logic signed [WIDE-1:0] MAX_W = WIDE'((1 <<< (COORD_W - 1)) - 1);
  localparam logic signed [WIDE-1:0] MIN_W = -MAX_W - WIDE'(1);

  function automatic logic signed [COORD_W-1:0] satW(input logic signed [WIDE-1:0] v);
    if (v > MAX_W)      satW = MAX_W[COORD_W-1:0];
    else if (v < MIN_W) satW = MIN_W[COORD_W-1:0];
    else                satW = v[COORD_W-1:0];
  endfunction

  logic        [COORD_W-1:0] stepMag;
  logic signed [COORD_W-1:0] offX, offY, acc, accNext;
  logic signed [COORD_W:0]   baseX;
  logic signed [WIDE-1:0]    stepWide, accWide;

  assign stepWide = $signed({{(WIDE-COORD_W){1'b0}}, stepMag});
  assign accWide  = WIDE'(acc);

  always_comb begin
    accNext = acc;
    if (strobes.clearAcc)      accNext = '0;
    else if (strobes.stepUp)   accNext = satW(accWide + stepWide);
    else if (strobes.stepDown) accNext = satW(accWide - stepWide);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepMag <= '0;
      offX    <= '0;
      offY    <= '0;
      acc     <= '0;
      baseX   <= '0;
      physY   <= '0;
    end else begin
      acc <= accNext;
      if (strobes.wrStep) stepMag <= cfgWrData;
      if (strobes.wrOffX) offX    <= $signed(cfgWrData);
      if (strobes.wrOffY) offY    <= $signed(cfgWrData);
      if (strobes.loadCmd) begin
        baseX <= (COORD_W+1)'(offX) + (COORD_W+1)'(cmdX);
        physY <= satW(WIDE'(offY) + WIDE'(cmdY));
      end
    end
  end

  // Live correction: the latched sum minus this cycle's accumulator.
  assign physX = satW(WIDE'(baseX) - accWide);

  // R3: a forward step never lowers the accumulator
  p_acc_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepUp && !strobes.clearAcc) |=> (acc >= $past(acc)));

  // R4: a reverse step never raises the accumulator
  p_acc_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.stepDown && !strobes.clearAcc) |=> (acc <= $past(acc)));

  // R6: a step register write leaves the accumulator at zero
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStep |=> (acc == '0));

  // R7: an offset write alone leaves the presented Y untouched
  p_offy_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrOffY && !strobes.loadCmd) |=> $stable(physY));
endmodule

// File: rtl/galvo_coord_unit.sv
module galvo_coord_unit
  import gcu_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      quadA,
  input  logic                      quadB,
  input  logic                      cfgWrEn,
  input  logic        [ADDR_W-1:0]  cfgAddr,
  input  logic        [COORD_W-1:0] cfgWrData,
  input  logic                      cmdValid,
  output logic                      cmdReady,
  input  logic signed [COORD_W-1:0] cmdX,
  input  logic signed [COORD_W-1:0] cmdY,
  output logic                      outValid,
  input  logic                      outReady,
  output logic signed [COORD_W-1:0] physX,
  output logic signed [COORD_W-1:0] physY
);
  gcuStrobes_t strobes;

  gcu_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) ctrlU (
    .clk(clk), .rstN(rstN), .quadA(quadA), .quadB(quadB),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cmdValid(cmdValid),
    .outReady(outReady), .cmdReady(cmdReady), .outValid(outValid),
    .strobes(strobes)
  );

  gcu_datapath #(.COORD_W(COORD_W)) dataU (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrData(cfgWrData),
    .cmdX(cmdX), .cmdY(cmdY), .physX(physX), .physY(physY)
  );
endmodule

// File: tb/galvo_coord_unit_test.sv
module galvo_coord_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic quadA = 1'b0, quadB = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic cmdValid = 1'b0, outReady = 1'b0;
  logic signed [15:0] cmdX = '0, cmdY = '0;
  logic cmdReady, outValid;
  logic signed [15:0] physX, physY;

  int nChecks = 0, nFail = 0;
  int grayIdx = 0;
  int accModel = 0;

  always #4 clk = ~clk;

  galvo_coord_unit uut (
    .clk(clk), .rstN(rstN), .quadA(quadA), .quadB(quadB),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdX(cmdX), .cmdY(cmdY),
    .outValid(outValid), .outReady(outReady), .physX(physX), .physY(physY)
  );

  // Rows: offX, offY, step, encoder moves (+fwd/-rev), vx, vy
  localparam int NVEC = 6;
  localparam int VEC [NVEC][6] = '{
    '{0,      0,      1,     0,  100,    -200},
    '{1000,   -500,   3,     4,  10,     20},
    '{-300,   40,     7,     -5, 0,      0},
    '{28672,  -28672, 0,     0,  28672,  -28672},
    '{-32768, 0,      100,   3,  -32768, 5},
    '{0,      0,      65535, 2,  0,      0}
  };

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(int addr, int data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = 2'(addr); cfgWrData = 16'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic setGray(int idx);
    // forward order of {A,B}: 00,10,11,01
    quadA = (idx == 1 || idx == 2);
    quadB = (idx == 2 || idx == 3);
    repeat (5) @(negedge clk);
  endtask

  task automatic moveEnc(int n, int stepMag);
    for (int k = 0; k < (n < 0 ? -n : n); k++) begin
      grayIdx = (n > 0) ? (grayIdx + 1) % 4 : (grayIdx + 3) % 4;
      setGray(grayIdx);
      accModel = sat16(n > 0 ? accModel + stepMag : accModel - stepMag);
    end
  endtask

  task automatic sendCmd(int vx, int vy);
    @(negedge clk);
    cmdValid = 1'b1; cmdX = 16'(vx); cmdY = 16'(vy);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic ackOut();
    @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int offX, offY, stepMag;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 outValid", int'(outValid), 0);
    check("R11 cmdReady", int'(cmdReady), 1);
    sendCmd(5, 6);
    check("R11 zero offsets/acc X", int'(physX), 5);
    check("R11 zero offsets Y", int'(physY), 6);
    ackOut();

    // Table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      offX = VEC[i][0]; offY = VEC[i][1]; stepMag = VEC[i][2];
      writeReg(0, stepMag); accModel = 0;
      writeReg(1, offX);
      writeReg(2, offY);
      moveEnc(VEC[i][3], stepMag);
      sendCmd(VEC[i][4], VEC[i][5]);
      check("R1/R3/R4/R5 physX", int'(physX), sat16(offX + VEC[i][4] - accModel));
      check("R2/R5 physY", int'(physY), sat16(offY + VEC[i][5]));
      ackOut();
      check("R8 valid drops after ack", int'(outValid), 0);
    end

    // R9: live correction while held
    writeReg(0, 5); accModel = 0;
    writeReg(1, 0);
    writeReg(2, 0);
    sendCmd(50, 7);
    check("R9 initial X", int'(physX), 50);
    moveEnc(1, 5);
    check("R9 X follows encoder", int'(physX), 45);
    check("R9 still valid", int'(outValid), 1);

    // R7: offset writes do not touch presented output
    writeReg(1, 1000);
    writeReg(2, 1000);
    check("R7 X unchanged", int'(physX), 45);
    check("R7 Y unchanged", int'(physY), 7);

    // R8: command ignored while held without ready
    check("R8 cmdReady low", int'(cmdReady), 0);
    sendCmd(9, 9);
    check("R8 ignored X", int'(physX), 45);
    check("R8 ignored Y", int'(physY), 7);

    // R8: overwrite allowed when ready in the same cycle; R7 new offset now used
    @(negedge clk);
    outReady = 1'b1; cmdValid = 1'b1; cmdX = 16'sd9; cmdY = 16'sd9;
    @(negedge clk);
    outReady = 1'b0; cmdValid = 1'b0;
    check("R8 overwrite valid", int'(outValid), 1);
    check("R7 new offset X", int'(physX), 1000 + 9 - 5);
    check("R7 new offset Y", int'(physY), 1009);

    // R10: two-bit jump gives no step
    grayIdx = (grayIdx + 2) % 4;
    setGray(grayIdx);
    check("R10 no step on double jump", int'(physX), 1004);
    moveEnc(1, 5);
    check("R3 step after jump", int'(physX), 999);

    // R6: step write zeroes accumulator
    writeReg(0, 5);
    check("R6 acc cleared", int'(physX), 1009);
    // unused address 3 has no effect
    writeReg(3, 16'h1234);
    check("R6 unused address ignored", int'(physX), 1009);
    ackOut();

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule